// File: doc/BRIEF.md
# Hybrid Scratchpad Placement Controller

This block sits in front of two scratchpad banks of very different character: a large, dense nonvolatile bank whose writes are slow, and a small SRAM bank that is fast for both reads and writes. Every request carries a class flag and an urgency flag. The class flag separates read-only evaluation-key blocks from rewritable ciphertext or intermediate blocks. The controller uses these flags to decide which bank serves the request. Key blocks are only ever read, and only from the nonvolatile bank. Ciphertexts live in SRAM when they are urgent or already resident. Non-urgent ciphertext traffic that misses SRAM passes straight to the nonvolatile bank.

SRAM is organised as a fully associative set of block slots. A residency table holds a valid bit, a block address and a least-recently-used age for each slot. An urgent ciphertext miss with no free slot starts a swap. The controller reads the oldest resident block out of SRAM, writes it back to the nonvolatile bank at its own address, and only then allocates its slot to the new block. For a read, it fills that slot from the nonvolatile bank. The requester is stalled for the whole swap. Each bank access is a level request that is held until the bank's done pulse, so the bank latencies can vary freely.

Top module: `spm_hybrid_ctrl`

## Requirements
- R1: After synchronous reset, req_ready is 1, rsp_valid is 0, neither bank request is raised, and no SRAM slot holds a block.
- R2: A read with req_key=1 performs exactly one nonvolatile read at nv_addr=req_addr and returns that data; it never places the block in SRAM.
- R3: A write with req_key=1 is rejected: rsp_valid and rsp_err pulse together in the cycle after acceptance, no bank request is raised, and the stored block keeps its old value.
- R4: A ciphertext (req_key=0) request whose address is resident is served by one SRAM access regardless of req_urgent, and a read returns the most recently written value of that address.
- R5: On a swap, the victim is the resident block least recently accepted as a hit or an allocation; it is written to the nonvolatile bank at its own block address with its latest data.
- R6: An urgent ciphertext miss with a free slot allocates the block into SRAM. A write performs a single SRAM write. A read performs a nonvolatile read and then an SRAM write, and returns the nonvolatile data.
- R7: A non-urgent ciphertext miss performs a single nonvolatile access at req_addr and allocates nothing, so a repeat of it misses again.
- R8: SRAM holds 2^ADDR_W/RATIO blocks. An urgent miss while every slot is held runs, in this order: an SRAM read of the victim, a nonvolatile write-back, then (for reads) a nonvolatile read, and then an SRAM write. req_ready stays 0 until the response.
- R9: Each bank access holds its request until that bank's done. The response pulse is registered on the edge that samples the last done, so a bank access of L cycles costs L+1 cycles.
- R10: At most one bank is requested at a time, and request fields are steady until done. rsp_err is raised only for key writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_key | input | 1 | 1 = evaluation-key block, 0 = ciphertext block |
| req_urgent | input | 1 | 1 = urgent small transfer, steer toward SRAM |
| req_addr | input | ADDR_W | Block address (nonvolatile bank address) |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | DATA_W | Read data (0 for writes) |
| sram_req | output | 1 | SRAM access request, held until done |
| sram_we | output | 1 | SRAM write enable |
| sram_slot | output | SLOT_W | SRAM slot index |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_done | input | 1 | SRAM access complete |
| sram_rdata | input | DATA_W | SRAM read data, valid with done |
| nv_req | output | 1 | Nonvolatile access request, held until done |
| nv_we | output | 1 | Nonvolatile write enable |
| nv_addr | output | ADDR_W | Nonvolatile block address |
| nv_wdata | output | DATA_W | Nonvolatile write data |
| nv_done | input | 1 | Nonvolatile access complete |
| nv_rdata | input | DATA_W | Nonvolatile read data, valid with done |

## Verification
With SRAM access taking S cycles, nonvolatile reads R and writes W, the response is due D cycles after the accepting edge. A rejected key write has D=0. A hit has D=S+1. A key read or non-urgent read miss has D=R+1, and a non-urgent write miss has D=W+1. An urgent miss with a free slot has D=S+1 for a write and D=R+S+2 for a read. A swap adds S+W+2 to these. The bench computes D from its own model and samples at every falling edge after acceptance, failing a response that comes early or late. It also fails if req_ready rises before the response. After each response it compares the ordered list of bank accesses (bank, direction, nonvolatile address) against the expected list, which pins the victim address and the swap order.

// File: rtl/spm_pkg.sv
package spm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRAM_ACC,
        ST_NV_ACC,
        ST_EV_RD,
        ST_EV_WR,
        ST_FILL_RD,
        ST_FILL_WR
    } seq_state_e;

    typedef enum logic {
        BANK_SRAM = 1'b0,
        BANK_NV   = 1'b1
    } bank_e;

    typedef struct packed {
        logic write;
        logic key;
        logic urgent;
    } req_attr_t;

    localparam int DEFAULT_RATIO = 8;

    function automatic int slot_count(input int addr_w, input int ratio);
        return (1 << addr_w) / ratio;
    endfunction

endpackage

// File: rtl/spm_resid_table.sv
module spm_resid_table #(
    parameter int AW     = 6,
    parameter int NSLOT  = 8,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     lk_addr,
    output logic              lk_hit,
    output logic [SLOT_W-1:0] lk_slot,
    output logic              tbl_full,
    output logic [SLOT_W-1:0] free_slot,
    output logic [SLOT_W-1:0] vic_slot,
    output logic [AW-1:0]     vic_tag,
    input  logic              upd_en,
    input  logic [SLOT_W-1:0] upd_slot,
    input  logic              upd_install,
    input  logic [AW-1:0]     upd_tag
);
    localparam logic [SLOT_W-1:0] OLDEST = SLOT_W'(NSLOT - 1);

    logic [NSLOT-1:0]  valid_q;
    logic [AW-1:0]     tag_q [NSLOT];
    logic [SLOT_W-1:0] age_q [NSLOT];
    logic [NSLOT-1:0]  hit_vec;
    logic [NSLOT-1:0]  oldest_vec;
    logic [SLOT_W:0]   ref_age;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign hit_vec[g]    = valid_q[g] && (tag_q[g] == lk_addr);
        assign oldest_vec[g] = valid_q[g] && (age_q[g] == OLDEST);
    end

    assign lk_hit   = |hit_vec;
    assign tbl_full = &valid_q;

    always_comb begin
        lk_slot   = '0;
        free_slot = '0;
        vic_slot  = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (hit_vec[i])    lk_slot   = SLOT_W'(i);
            if (!valid_q[i])   free_slot = SLOT_W'(i);
            if (oldest_vec[i]) vic_slot  = SLOT_W'(i);
        end
    end

    assign vic_tag = tag_q[vic_slot];

    // A slot being filled fresh counts as older than every resident block.
    assign ref_age = valid_q[upd_slot] ? {1'b0, age_q[upd_slot]}
                                       : (SLOT_W + 1)'(NSLOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < NSLOT; i++) begin
                tag_q[i] <= '0;
                age_q[i] <= '0;
            end
        end else if (upd_en) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (SLOT_W'(i) == upd_slot) begin
                    age_q[i] <= '0;
                end else if (valid_q[i] && ({1'b0, age_q[i]} < ref_age)) begin
                    age_q[i] <= age_q[i] + 1'b1;
                end
            end
            if (upd_install) begin
                valid_q[upd_slot] <= 1'b1;
                tag_q[upd_slot]   <= upd_tag;
            end
        end
    end

    // R4: one block address is never resident in two slots
    p_tag_unique_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R5: a full table always has exactly one least-recently-used victim
    p_one_victim_r5: assert property (@(posedge clk) disable iff (rst)
        tbl_full |-> ($countones(oldest_vec) == 1));

endmodule

// File: rtl/spm_seq.sv
module spm_seq
    import spm_pkg::*;
#(
    parameter int AW     = 6,
    parameter int DW     = 32,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  req_attr_t         req_attr,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DW-1:0]     rsp_rdata,
    input  logic              lk_hit,
    input  logic [SLOT_W-1:0] lk_slot,
    input  logic              tbl_full,
    input  logic [SLOT_W-1:0] free_slot,
    input  logic [SLOT_W-1:0] vic_slot,
    input  logic [AW-1:0]     vic_tag,
    output logic              upd_en,
    output logic [SLOT_W-1:0] upd_slot,
    output logic              upd_install,
    output logic [AW-1:0]     upd_tag,
    output logic              op_valid,
    output bank_e             op_bank,
    output logic              op_we,
    output logic [AW-1:0]     op_addr,
    output logic [SLOT_W-1:0] op_slot,
    output logic [DW-1:0]     op_wdata,
    input  logic              op_done,
    input  logic [DW-1:0]     op_rdata
);
    seq_state_e        state_q;
    req_attr_t         cur_q;
    logic [AW-1:0]     cur_addr_q;
    logic [DW-1:0]     cur_wdata_q;
    logic [SLOT_W-1:0] slot_q;
    logic [AW-1:0]     vic_addr_q;
    logic [DW-1:0]     xfer_q;
    logic              alloc_q;
    logic              evict_q;
    logic              wb_done_q;

    assign req_ready = (state_q == ST_IDLE);
    assign op_slot   = slot_q;

    always_comb begin
        op_valid = 1'b1;
        op_bank  = BANK_SRAM;
        op_we    = 1'b0;
        op_addr  = cur_addr_q;
        op_wdata = cur_wdata_q;
        unique case (state_q)
            ST_SRAM_ACC: op_we = cur_q.write;
            ST_NV_ACC: begin
                op_bank = BANK_NV;
                op_we   = cur_q.write;
            end
            ST_EV_RD: ;
            ST_EV_WR: begin
                op_bank  = BANK_NV;
                op_we    = 1'b1;
                op_addr  = vic_addr_q;
                op_wdata = xfer_q;
            end
            ST_FILL_RD: op_bank = BANK_NV;
            ST_FILL_WR: begin
                op_we    = 1'b1;
                op_wdata = xfer_q;
            end
            default: op_valid = 1'b0;
        endcase
    end

    assign upd_en      = op_done && ((state_q == ST_SRAM_ACC) || (state_q == ST_FILL_WR));
    assign upd_slot    = slot_q;
    assign upd_install = alloc_q;
    assign upd_tag     = cur_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cur_q       <= '0;
            cur_addr_q  <= '0;
            cur_wdata_q <= '0;
            slot_q      <= '0;
            vic_addr_q  <= '0;
            xfer_q      <= '0;
            alloc_q     <= 1'b0;
            evict_q     <= 1'b0;
            wb_done_q   <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_err     <= 1'b0;
            rsp_rdata   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_q       <= req_attr;
                        cur_addr_q  <= req_addr;
                        cur_wdata_q <= req_wdata;
                        alloc_q     <= 1'b0;
                        evict_q     <= 1'b0;
                        wb_done_q   <= 1'b0;
                        if (req_attr.key && req_attr.write) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                            rsp_rdata <= '0;
                        end else if (req_attr.key) begin
                            state_q <= ST_NV_ACC;
                        end else if (lk_hit) begin
                            slot_q  <= lk_slot;
                            state_q <= ST_SRAM_ACC;
                        end else if (!req_attr.urgent) begin
                            state_q <= ST_NV_ACC;
                        end else if (tbl_full) begin
                            slot_q     <= vic_slot;
                            vic_addr_q <= vic_tag;
                            alloc_q    <= 1'b1;
                            evict_q    <= 1'b1;
                            state_q    <= ST_EV_RD;
                        end else begin
                            slot_q  <= free_slot;
                            alloc_q <= 1'b1;
                            state_q <= req_attr.write ? ST_SRAM_ACC : ST_FILL_RD;
                        end
                    end
                end
                ST_SRAM_ACC, ST_NV_ACC: begin
                    if (op_done) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= cur_q.write ? '0 : op_rdata;
                        state_q   <= ST_IDLE;
                    end
                end
                ST_EV_RD: begin
                    if (op_done) begin
                        xfer_q  <= op_rdata;
                        state_q <= ST_EV_WR;
                    end
                end
                ST_EV_WR: begin
                    if (op_done) begin
                        wb_done_q <= 1'b1;
                        state_q   <= cur_q.write ? ST_SRAM_ACC : ST_FILL_RD;
                    end
                end
                ST_FILL_RD: begin
                    if (op_done) begin
                        xfer_q  <= op_rdata;
                        state_q <= ST_FILL_WR;
                    end
                end
                ST_FILL_WR: begin
                    if (op_done) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= xfer_q;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3: no bank write is ever issued on behalf of a key request
    p_key_never_written_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_we) |-> !cur_q.key);

    // R10: an error response only follows acceptance of a key write
    p_err_only_key_write_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> $past(req_valid && req_ready && req_attr.key && req_attr.write));

    // R8: the victim write-back has completed before the freed slot is allocated
    p_wb_before_alloc_r8: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_install && evict_q) |-> wb_done_q);

    // R9: a response follows either a bank done or an accepted request
    p_rsp_after_done_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(op_done || (req_valid && req_ready)));

endmodule

// File: rtl/spm_chan_mux.sv
module spm_chan_mux
    import spm_pkg::*;
#(
    parameter int AW     = 6,
    parameter int DW     = 32,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  bank_e             op_bank,
    input  logic              op_we,
    input  logic [AW-1:0]     op_addr,
    input  logic [SLOT_W-1:0] op_slot,
    input  logic [DW-1:0]     op_wdata,
    output logic              op_done,
    output logic [DW-1:0]     op_rdata,
    output logic              sram_req,
    output logic              sram_we,
    output logic [SLOT_W-1:0] sram_slot,
    output logic [DW-1:0]     sram_wdata,
    input  logic              sram_done,
    input  logic [DW-1:0]     sram_rdata,
    output logic              nv_req,
    output logic              nv_we,
    output logic [AW-1:0]     nv_addr,
    output logic [DW-1:0]     nv_wdata,
    input  logic              nv_done,
    input  logic [DW-1:0]     nv_rdata
);
    logic to_nv;

    assign to_nv      = (op_bank == BANK_NV);
    assign sram_req   = op_valid && !to_nv;
    assign nv_req     = op_valid && to_nv;
    assign sram_we    = op_we;
    assign nv_we      = op_we;
    assign sram_slot  = op_slot;
    assign nv_addr    = op_addr;
    assign sram_wdata = op_wdata;
    assign nv_wdata   = op_wdata;
    assign op_done    = to_nv ? (nv_req && nv_done) : (sram_req && sram_done);
    assign op_rdata   = to_nv ? nv_rdata : sram_rdata;

    // R10: a bank request and its fields hold steady until its done
    p_req_held_r10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_done) |=> (op_valid && $stable(op_bank) && $stable(op_we)
                                    && $stable(op_addr) && $stable(op_slot) && $stable(op_wdata)));

endmodule

// File: rtl/spm_hybrid_ctrl.sv
module spm_hybrid_ctrl
    import spm_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int RATIO  = DEFAULT_RATIO,
    localparam int NSLOT  = slot_count(ADDR_W, RATIO),
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_key,
    input  logic              req_urgent,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              sram_req,
    output logic              sram_we,
    output logic [SLOT_W-1:0] sram_slot,
    output logic [DATA_W-1:0] sram_wdata,
    input  logic              sram_done,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic              nv_req,
    output logic              nv_we,
    output logic [ADDR_W-1:0] nv_addr,
    output logic [DATA_W-1:0] nv_wdata,
    input  logic              nv_done,
    input  logic [DATA_W-1:0] nv_rdata
);
    req_attr_t         attr;
    logic              lk_hit, tbl_full, upd_en, upd_install;
    logic [SLOT_W-1:0] lk_slot, free_slot, vic_slot, upd_slot, op_slot;
    logic [ADDR_W-1:0] vic_tag, upd_tag, op_addr;
    logic              op_valid, op_we, op_done;
    bank_e             op_bank;
    logic [DATA_W-1:0] op_wdata, op_rdata;

    assign attr = '{write: req_write, key: req_key, urgent: req_urgent};

    spm_resid_table #(.AW(ADDR_W), .NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_table (
        .clk(clk), .rst(rst),
        .lk_addr(req_addr), .lk_hit(lk_hit), .lk_slot(lk_slot),
        .tbl_full(tbl_full), .free_slot(free_slot),
        .vic_slot(vic_slot), .vic_tag(vic_tag),
        .upd_en(upd_en), .upd_slot(upd_slot),
        .upd_install(upd_install), .upd_tag(upd_tag)
    );

    spm_seq #(.AW(ADDR_W), .DW(DATA_W), .SLOT_W(SLOT_W)) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_attr(attr),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .lk_hit(lk_hit), .lk_slot(lk_slot), .tbl_full(tbl_full),
        .free_slot(free_slot), .vic_slot(vic_slot), .vic_tag(vic_tag),
        .upd_en(upd_en), .upd_slot(upd_slot),
        .upd_install(upd_install), .upd_tag(upd_tag),
        .op_valid(op_valid), .op_bank(op_bank), .op_we(op_we),
        .op_addr(op_addr), .op_slot(op_slot), .op_wdata(op_wdata),
        .op_done(op_done), .op_rdata(op_rdata)
    );

    spm_chan_mux #(.AW(ADDR_W), .DW(DATA_W), .SLOT_W(SLOT_W)) u_mux (
        .clk(clk), .rst(rst),
        .op_valid(op_valid), .op_bank(op_bank), .op_we(op_we),
        .op_addr(op_addr), .op_slot(op_slot), .op_wdata(op_wdata),
        .op_done(op_done), .op_rdata(op_rdata),
        .sram_req(sram_req), .sram_we(sram_we), .sram_slot(sram_slot),
        .sram_wdata(sram_wdata), .sram_done(sram_done), .sram_rdata(sram_rdata),
        .nv_req(nv_req), .nv_we(nv_we), .nv_addr(nv_addr),
        .nv_wdata(nv_wdata), .nv_done(nv_done), .nv_rdata(nv_rdata)
    );

endmodule

// File: tb/spm_hybrid_ctrl_bench.sv
module spm_hybrid_ctrl_bench;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int NBLK = 1 << AW;
    localparam int NSLOT = NBLK / 8;
    localparam int SW = $clog2(NSLOT);
    localparam int SR_LAT = 1;
    localparam int NVR_LAT = 2;
    localparam int NVW_LAT = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, req_key = 1'b0, req_urgent = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic sram_req, sram_we, sram_done;
    logic [SW-1:0] sram_slot;
    logic [DW-1:0] sram_wdata, sram_rdata;
    logic nv_req, nv_we, nv_done;
    logic [AW-1:0] nv_addr;
    logic [DW-1:0] nv_wdata, nv_rdata;

    always #5 clk = ~clk;

    spm_hybrid_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RATIO(8)) u_spm_hybrid_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_key(req_key), .req_urgent(req_urgent),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .sram_req(sram_req), .sram_we(sram_we), .sram_slot(sram_slot),
        .sram_wdata(sram_wdata), .sram_done(sram_done), .sram_rdata(sram_rdata),
        .nv_req(nv_req), .nv_we(nv_we), .nv_addr(nv_addr),
        .nv_wdata(nv_wdata), .nv_done(nv_done), .nv_rdata(nv_rdata));

    // ---------------- behavioural bank models ----------------
    logic [DW-1:0] nv_mem [NBLK];
    logic [DW-1:0] sram_mem [NSLOT];
    int sr_cnt, nv_cnt;
    int ops_q[$];
    int both_bad = 0;

    initial begin
        sram_done = 1'b0; nv_done = 1'b0;
        sram_rdata = '0; nv_rdata = '0;
        for (int i = 0; i < NBLK; i++) nv_mem[i] = 32'h1000 + i * 7;
        for (int i = 0; i < NSLOT; i++) sram_mem[i] = '0;
    end

    always @(posedge clk) begin
        sram_done <= 1'b0;
        if (rst) sr_cnt <= 0;
        else if (sram_req && !sram_done) begin
            if (sr_cnt == SR_LAT - 1) begin
                sram_done  <= 1'b1;
                sr_cnt     <= 0;
                sram_rdata <= sram_mem[sram_slot];
                if (sram_we) sram_mem[sram_slot] <= sram_wdata;
                ops_q.push_back(int'(sram_we) * 128);
            end else sr_cnt <= sr_cnt + 1;
        end
    end

    always @(posedge clk) begin
        nv_done <= 1'b0;
        if (rst) nv_cnt <= 0;
        else if (nv_req && !nv_done) begin
            if (nv_cnt == (nv_we ? NVW_LAT : NVR_LAT) - 1) begin
                nv_done  <= 1'b1;
                nv_cnt   <= 0;
                nv_rdata <= nv_mem[nv_addr];
                if (nv_we) nv_mem[nv_addr] <= nv_wdata;
                ops_q.push_back(256 + int'(nv_we) * 128 + int'(nv_addr));
            end else nv_cnt <= nv_cnt + 1;
        end
    end

    always @(negedge clk) if (!rst && sram_req && nv_req) both_bad++;

    // ---------------- reference model ----------------
    logic [DW-1:0] val [NBLK];
    int lru[$];              // front = most recently used
    int tests = 0, fails = 0;
    bit finished = 1'b0;

    function automatic int code(bit nv, bit we, int a);
        return nv ? (256 + int'(we) * 128 + a) : int'(we) * 128;
    endfunction

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic do_req(bit wr, bit key, bit urg, int addr, logic [DW-1:0] wd);
        int exp_ops[$];
        int exp_d = 0;
        int idx = -1;
        int n;
        int busy_bad = 0;
        bit exp_err = 1'b0;
        logic [DW-1:0] exp_rd = '0;
        string rq;
        for (int i = 0; i < lru.size(); i++) if (lru[i] == addr) idx = i;
        if (key && wr) begin
            rq = "R3"; exp_err = 1'b1; exp_d = 0;
        end else if (key) begin
            rq = "R2"; exp_ops.push_back(code(1, 0, addr)); exp_d = NVR_LAT + 1; exp_rd = val[addr];
        end else if (idx >= 0) begin
            rq = "R4"; exp_ops.push_back(code(0, wr, 0)); exp_d = SR_LAT + 1;
            lru.delete(idx); lru.push_front(addr);
            if (wr) val[addr] = wd; else exp_rd = val[addr];
        end else if (!urg) begin
            rq = "R7"; exp_ops.push_back(code(1, wr, addr));
            exp_d = (wr ? NVW_LAT : NVR_LAT) + 1;
            if (wr) val[addr] = wd; else exp_rd = val[addr];
        end else begin
            rq = "R6";
            if (lru.size() == NSLOT) begin
                int vic = lru.pop_back();
                rq = "R8";
                exp_ops.push_back(code(0, 0, 0));
                exp_ops.push_back(code(1, 1, vic));
                exp_d += SR_LAT + NVW_LAT + 2;
            end
            if (wr) begin
                exp_ops.push_back(code(0, 1, 0)); exp_d += SR_LAT + 1; val[addr] = wd;
            end else begin
                exp_ops.push_back(code(1, 0, addr)); exp_ops.push_back(code(0, 1, 0));
                exp_d += NVR_LAT + SR_LAT + 2; exp_rd = val[addr];
            end
            lru.push_front(addr);
        end

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        ops_q.delete();
        req_valid = 1'b1; req_write = wr; req_key = key; req_urgent = urg;
        req_addr = AW'(addr); req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!rsp_valid && n < 200) begin
            if (req_ready) busy_bad++;
            @(negedge clk);
            n++;
        end
        chk(n == exp_d + 1, "R9", {rq, " response cycle"}, n - 1, exp_d);
        chk(busy_bad == 0, "R8", {rq, " ready low while busy"}, busy_bad, 0);
        chk(rsp_err == exp_err, (exp_err ? "R3" : "R10"), {rq, " rsp_err"}, rsp_err, exp_err);
        if (!wr) chk(rsp_rdata == exp_rd, rq, "read data", rsp_rdata, exp_rd);
        begin
            bit same = (ops_q.size() == exp_ops.size());
            int act0 = (ops_q.size() > 0) ? ops_q[0] : -1;
            int exp0 = (exp_ops.size() > 0) ? exp_ops[0] : -1;
            if (same) for (int i = 0; i < exp_ops.size(); i++) begin
                if (ops_q[i] != exp_ops[i]) begin
                    same = 1'b0; act0 = ops_q[i]; exp0 = exp_ops[i];
                end
            end
            chk(same, (rq == "R8") ? "R5" : rq, "bank access list", act0, exp0);
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < NBLK; i++) val[i] = 32'h1000 + i * 7;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", rsp_valid, 0);
        chk(!sram_req && !nv_req, "R1", "reset bank idle", {sram_req, nv_req}, 0);

        // R1: empty SRAM, first urgent read is a fill
        do_req(0, 0, 1, 9, '0);
        // R2 / R3 key traffic
        do_req(0, 1, 0, 40, '0);
        do_req(1, 1, 1, 40, 32'hDEAD_0001);
        do_req(0, 1, 1, 40, '0);
        // R6 fill the remaining slots by urgent writes
        for (int a = 0; a < 7; a++) do_req(1, 0, 1, a, 32'hA000 + a);
        // R4 hits with both urgency values
        do_req(0, 0, 1, 3, '0);
        do_req(0, 0, 0, 5, '0);
        do_req(1, 0, 0, 6, 32'hBEEF_0006);
        do_req(0, 0, 0, 6, '0);
        // R7 non-urgent misses do not allocate
        do_req(1, 0, 0, 20, 32'hC000_0020);
        do_req(0, 0, 0, 20, '0);
        do_req(0, 0, 0, 20, '0);
        // R8 / R5 swaps
        do_req(0, 0, 1, 21, '0);
        do_req(1, 0, 1, 22, 32'hC000_0022);
        do_req(0, 0, 1, 9, '0);
        do_req(0, 0, 1, 0, '0);
        // R3 key write to a resident address leaves it intact
        do_req(1, 1, 0, 3, 32'hDEAD_0003);
        do_req(0, 0, 1, 3, '0);
        // mixed traffic
        begin
            int unsigned r = 32'h1234_5678;
            for (int k = 0; k < 80; k++) begin
                r = r * 1664525 + 1013904223;
                case (r[31:29])
                    3'd0: do_req(0, 1, r[20], 32 + int'(r[15:11]), '0);
                    3'd1: do_req(1, 1, r[20], int'(r[16:11]), r);
                    default: do_req(r[22], 0, r[23], int'(r[18:11]) % 14, r);
                endcase
            end
        end
        chk(both_bad == 0, "R10", "one bank at a time", both_bad, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule